// File: doc/BRIEF.md
# Vector Length Configuration Unit

This execute-stage unit carries out the instruction that configures variable-length vector work. It receives a decoded 32-bit instruction word together with the value of the RA source register and the loop-count (CTR) register. It owns the vector state: the maximum vector length, the active vector length, the source and destination element indices, and a vertical-first flag. Depending on three mode bits in the word, it loads the maximum length from the immediate, picks the active length from one of three sources and clamps it, reads the current length back, or advances the element indices to the next enabled element.

Each accepted instruction produces one registered result one cycle later. The result holds an optional write-back to the RT register and the four condition bits of CR0. The condition bits describe the resulting vector length, not the RT value, and they flag a request that had to be clipped. The next-enabled-element search that uses the predicate is not part of the unit: for each step it arrives as a pair of index inputs.

Top module: `vlcfg_unit`

## Requirements
- R1: Fields are taken with bit 0 as the most significant bit of `insn`: primary opcode in bits 0-5 (must equal parameter OPC_CODE, default 22), RT in 6-10, RA in 11-15, immediate SVi in 16-22, ms in 23, vs in 24, vf in 25, sub-opcode in 26-30 (must equal 0b11011), Rc in 31. A word whose opcode or sub-opcode does not match still completes, but writes neither RT nor CR0 and changes no state.
- R2: With ms=1, the maximum length becomes SVi+1 (1 to 128). With ms=1 and vs=0, the active length is lowered to the new maximum if it exceeded it. Any instruction with ms=1 or vs=1 clears both element indices to 0.
- R3: With vs=1, RA field 0 and RT field 0, the active length becomes MIN(maximum, SVi+1) and RT is not written. When ms=1 as well, the clamp uses the maximum length loaded by the same instruction.
- R4: With vs=1, RA field 0 and RT field nonzero, the active length becomes MIN(maximum, CTR), and RT receives that value.
- R5: With vs=1 and RA field nonzero, the active length becomes MIN(maximum, RA value). RT receives that value when the RT field is nonzero.
- R6: When Rc=1, CR0 is written as cr0[3:0] = {LT, GT, EQ, SO}, with LT=0. For set and read forms, EQ=1 exactly when the resulting active length is 0 and GT=1 exactly when it is nonzero. When Rc=0, CR0 is not written.
- R7: SO is 1 only when a length requested from the immediate or from CTR exceeded the maximum and was clipped. A request taken from RA never sets SO, and neither do the step and read forms.
- R8: With ms=vs=vf=0, no state changes, and RT (when nonzero) receives the current active length.
- R9: With vf=1 and ms=vs=0, the source and destination indices take the values on `nxt_src` and `nxt_dst`. If either value is at or beyond the active length, both indices wrap to 0, and with Rc=1 CR0 has EQ=1, GT=0. Otherwise CR0 has EQ=0, GT=1.
- R10: In the step form, when the RT field is nonzero, SVi=5 writes the new source index to RT and SVi=6 writes the new destination index. Any other SVi value writes nothing.
- R11: In set forms (ms=1 or vs=1), the vertical-first flag takes the vf bit. The step and read forms leave it unchanged.
- R12: Synchronous reset gives maximum length 1, active length 0, both indices 0, flag 0 and no valid result. An instruction is accepted when `in_valid` and `in_ready` are both high, and its result appears with `out_valid` on the next cycle. `in_ready` is low while a result is held for an `out_ready` that is low, and during that time the result and the state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| insn | input | 32 | Instruction word |
| ra_val | input | XLEN | Value read from RA |
| ctr_val | input | XLEN | Loop-count register value |
| nxt_src | input | VLW | Next enabled source element index |
| nxt_dst | input | VLW | Next enabled destination element index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| rt_we | output | 1 | RT write-back enable |
| rt_idx | output | 5 | RT register number |
| rt_data | output | XLEN | RT write-back value |
| cr0_we | output | 1 | CR0 write enable |
| cr0 | output | 4 | {LT, GT, EQ, SO} |
| mvl | output | VLW | Maximum vector length |
| vl | output | VLW | Active vector length |
| srcstep | output | VLW | Source element index |
| dststep | output | VLW | Destination element index |
| vfirst | output | 1 | Vertical-first flag |

## Verification
The hardest case to reach is the wrap at the end of the vector in step mode. The element indices must climb from zero to the active length through several back-to-back step instructions, and at the same time a set instruction must not land in between and clear them. The bench reaches it directly: it sets a small length, then issues a chain of step words whose next-element inputs go up from its own index model, sometimes skipping elements, until they cross the length. Random traffic then mixes steps, clipped requests from all three sources, and malformed words against the same model.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int SVI_W = 7;
  localparam int VLW   = SVI_W + 1;
  localparam logic [4:0] SUB_OPC = 5'b11011;

  // Field layout overlays insn[31:0]; instruction bit 0 is insn[31].
  typedef struct packed {
    logic [5:0]       opc;
    logic [4:0]       rt;
    logic [4:0]       ra;
    logic [SVI_W-1:0] svi;
    logic             ms;
    logic             vs;
    logic             vf;
    logic [4:0]       xo;
    logic             rc;
  } vl_insn_t;

  typedef enum logic [1:0] {
    MD_NONE = 2'd0,
    MD_GET  = 2'd1,
    MD_STEP = 2'd2,
    MD_SET  = 2'd3
  } vl_mode_e;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter logic [5:0] OPC_CODE = 6'd22
) (
  input  logic [31:0] insn,
  output vl_insn_t    fld,
  output vl_mode_e    mode
);
  always_comb begin
    fld = vl_insn_t'(insn);
    if (fld.opc != OPC_CODE || fld.xo != SUB_OPC)
      mode = MD_NONE;
    else if (fld.ms || fld.vs)
      mode = MD_SET;
    else if (fld.vf)
      mode = MD_STEP;
    else
      mode = MD_GET;
  end
endmodule

// File: rtl/vlcfg_length.sv
module vlcfg_length
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             ms,
  input  logic             vs,
  input  logic             ra_nz,
  input  logic             rt_nz,
  input  logic [SVI_W-1:0] svi,
  input  logic [VLW-1:0]   mvl_cur,
  input  logic [VLW-1:0]   vl_cur,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  output logic [VLW-1:0]   mvl_nxt,
  output logic [VLW-1:0]   vl_nxt,
  output logic             clip_so
);
  localparam int PADW = XLEN - VLW;

  logic [VLW-1:0]  imm_len;
  logic [XLEN-1:0] req;
  logic [XLEN-1:0] lim;

  always_comb begin
    imm_len = {1'b0, svi} + VLW'(1);
    mvl_nxt = ms ? imm_len : mvl_cur;
    lim     = {{PADW{1'b0}}, mvl_nxt};
    if (ra_nz)       req = ra_val;
    else if (rt_nz)  req = ctr_val;
    else             req = {{PADW{1'b0}}, imm_len};
    clip_so = 1'b0;
    if (vs) begin
      if (req > lim) begin
        vl_nxt  = mvl_nxt;
        clip_so = !ra_nz;
      end else begin
        vl_nxt  = req[VLW-1:0];
      end
    end else begin
      vl_nxt = (vl_cur > mvl_nxt) ? mvl_nxt : vl_cur;
    end
  end
endmodule

// File: rtl/vlcfg_step.sv
module vlcfg_step
  import vlcfg_pkg::*;
(
  input  logic [VLW-1:0] vl_cur,
  input  logic [VLW-1:0] nxt_src,
  input  logic [VLW-1:0] nxt_dst,
  output logic [VLW-1:0] src_nxt,
  output logic [VLW-1:0] dst_nxt,
  output logic           at_end
);
  always_comb begin
    at_end  = (nxt_src >= vl_cur) || (nxt_dst >= vl_cur);
    src_nxt = at_end ? '0 : nxt_src;
    dst_nxt = at_end ? '0 : nxt_dst;
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int         XLEN     = 64,
  parameter logic [5:0] OPC_CODE = 6'd22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [31:0]             insn,
  input  logic [XLEN-1:0]         ra_val,
  input  logic [XLEN-1:0]         ctr_val,
  input  logic [vlcfg_pkg::VLW-1:0] nxt_src,
  input  logic [vlcfg_pkg::VLW-1:0] nxt_dst,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    rt_we,
  output logic [4:0]              rt_idx,
  output logic [XLEN-1:0]         rt_data,
  output logic                    cr0_we,
  output logic [3:0]              cr0,
  output logic [vlcfg_pkg::VLW-1:0] mvl,
  output logic [vlcfg_pkg::VLW-1:0] vl,
  output logic [vlcfg_pkg::VLW-1:0] srcstep,
  output logic [vlcfg_pkg::VLW-1:0] dststep,
  output logic                    vfirst
);
  localparam int PADW = XLEN - VLW;

  vl_insn_t       fld;
  vl_mode_e       mode;
  logic [VLW-1:0] mvl_nxt, vl_nxt, src_nxt, dst_nxt;
  logic           clip_so, at_end, accept;

  vlcfg_decode #(.OPC_CODE(OPC_CODE)) u_dec (
    .insn(insn), .fld(fld), .mode(mode)
  );

  vlcfg_length #(.XLEN(XLEN)) u_len (
    .ms(fld.ms), .vs(fld.vs), .ra_nz(fld.ra != 5'd0), .rt_nz(fld.rt != 5'd0),
    .svi(fld.svi), .mvl_cur(mvl), .vl_cur(vl), .ra_val(ra_val),
    .ctr_val(ctr_val), .mvl_nxt(mvl_nxt), .vl_nxt(vl_nxt), .clip_so(clip_so)
  );

  vlcfg_step u_step (
    .vl_cur(vl), .nxt_src(nxt_src), .nxt_dst(nxt_dst),
    .src_nxt(src_nxt), .dst_nxt(dst_nxt), .at_end(at_end)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mvl       <= VLW'(1);
      vl        <= '0;
      srcstep   <= '0;
      dststep   <= '0;
      vfirst    <= 1'b0;
      out_valid <= 1'b0;
      rt_we     <= 1'b0;
      rt_idx    <= '0;
      rt_data   <= '0;
      cr0_we    <= 1'b0;
      cr0       <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      rt_idx    <= fld.rt;
      cr0_we    <= (mode != MD_NONE) && fld.rc;
      rt_we     <= 1'b0;
      rt_data   <= '0;
      cr0       <= '0;
      case (mode)
        MD_SET: begin
          mvl     <= mvl_nxt;
          vl      <= vl_nxt;
          srcstep <= '0;
          dststep <= '0;
          vfirst  <= fld.vf;
          rt_we   <= (fld.rt != 5'd0);
          rt_data <= {{PADW{1'b0}}, vl_nxt};
          cr0     <= {1'b0, vl_nxt != '0, vl_nxt == '0, clip_so};
        end
        MD_GET: begin
          rt_we   <= (fld.rt != 5'd0);
          rt_data <= {{PADW{1'b0}}, vl};
          cr0     <= {1'b0, vl != '0, vl == '0, 1'b0};
        end
        MD_STEP: begin
          srcstep <= src_nxt;
          dststep <= dst_nxt;
          rt_we   <= (fld.rt != 5'd0) &&
                     (fld.svi == SVI_W'(5) || fld.svi == SVI_W'(6));
          rt_data <= {{PADW{1'b0}}, (fld.svi == SVI_W'(5)) ? src_nxt : dst_nxt};
          cr0     <= {1'b0, !at_end, at_end, 1'b0};
        end
        default: ;
      endcase
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] rt_data,
  input logic            cr0_we,
  input logic [3:0]      cr0,
  input logic [VLW-1:0]  mvl,
  input logic [VLW-1:0]  vl,
  input logic [VLW-1:0]  srcstep,
  input logic [VLW-1:0]  dststep
);
  assert_vl_within_mvl_R2: assert property (@(posedge clk) disable iff (rst)
    vl <= mvl);

  assert_mvl_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    mvl != '0);

  assert_steps_below_vl_R9: assert property (@(posedge clk) disable iff (rst)
    (srcstep == '0 || srcstep < vl) && (dststep == '0 || dststep < vl));

  assert_cr0_eq_gt_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cr0_we) |-> (cr0[2] != cr0[1]) && !cr0[3]);

  assert_result_held_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(rt_data) && $stable(cr0));

  assert_state_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(vl) && $stable(mvl) && $stable(srcstep));
endmodule

bind vlcfg_unit vlcfg_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .rt_data(rt_data), .cr0_we(cr0_we), .cr0(cr0),
  .mvl(mvl), .vl(vl), .srcstep(srcstep), .dststep(dststep)
);

// File: tb/vlcfg_unit_tb.sv
`timescale 1ns/1ps
module vlcfg_unit_tb;
  localparam int XLEN = 64;
  localparam int VLW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] insn = '0;
  logic [XLEN-1:0] ra_val = '0, ctr_val = '0;
  logic [VLW-1:0] nxt_src = '0, nxt_dst = '0;
  logic in_ready, out_valid, rt_we, cr0_we, vfirst;
  logic [4:0] rt_idx;
  logic [XLEN-1:0] rt_data;
  logic [3:0] cr0;
  logic [VLW-1:0] mvl, vl, srcstep, dststep;

  always #2.5 clk = ~clk;

  vlcfg_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .ra_val(ra_val), .ctr_val(ctr_val), .nxt_src(nxt_src),
    .nxt_dst(nxt_dst), .out_valid(out_valid), .out_ready(out_ready),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data), .cr0_we(cr0_we),
    .cr0(cr0), .mvl(mvl), .vl(vl), .srcstep(srcstep), .dststep(dststep),
    .vfirst(vfirst)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int e_mvl = 1, e_vl = 0, e_src = 0, e_dst = 0;
  bit e_vf = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int rt, input int ra, input int svi,
                                     input bit ms, input bit vs, input bit vf, input bit rc);
    return {6'd22, 5'(rt), 5'(ra), 7'(svi), ms, vs, vf, 5'b11011, rc};
  endfunction

  task automatic apply(input logic [31:0] w, input longint unsigned rav,
                       input longint unsigned ctv, input int ns, input int nd);
    int rt, ra, svi, nm, nv, x_data;
    bit ms, vs, vf, rc, ok_w, x_rtwe, x_so, x_eq;
    longint unsigned req;
    string tag;
    rt = int'(w[25:21]); ra = int'(w[20:16]); svi = int'(w[15:9]);
    ms = w[8]; vs = w[7]; vf = w[6]; rc = w[0];
    ok_w = (w[31:26] == 6'd22) && (w[5:1] == 5'b11011);
    x_rtwe = 0; x_data = 0; x_so = 0; x_eq = 0;
    if (!ok_w) begin
      tag = "R1"; rc = 0;
    end else if (ms || vs) begin
      nm = ms ? svi + 1 : e_mvl;
      if (vs) begin
        if (ra != 0)      begin req = rav; tag = "R5"; end
        else if (rt != 0) begin req = ctv; tag = "R4"; end
        else              begin req = longint'(svi + 1); tag = "R3"; end
        if (req > longint'(nm)) begin nv = nm; x_so = (ra == 0); end
        else nv = int'(req);
      end else begin
        tag = "R2";
        nv = (e_vl > nm) ? nm : e_vl;
      end
      e_mvl = nm; e_vl = nv; e_src = 0; e_dst = 0; e_vf = vf;
      x_rtwe = (rt != 0); x_data = nv; x_eq = (nv == 0);
    end else if (vf) begin
      tag = "R9";
      if (ns >= e_vl || nd >= e_vl) begin e_src = 0; e_dst = 0; x_eq = 1; end
      else begin e_src = ns; e_dst = nd; end
      x_rtwe = (rt != 0) && (svi == 5 || svi == 6);
      x_data = (svi == 5) ? e_src : e_dst;
    end else begin
      tag = "R8";
      x_rtwe = (rt != 0); x_data = e_vl; x_eq = (e_vl == 0);
    end
    @(negedge clk);
    insn = w; ra_val = rav; ctr_val = ctv;
    nxt_src = VLW'(ns); nxt_dst = VLW'(nd); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R12 out_valid", longint'(out_valid), 1);
    chk(rt_we == x_rtwe, {tag, " rt_we"}, longint'(rt_we), longint'(x_rtwe));
    if (x_rtwe) begin
      chk(rt_data == XLEN'(x_data), (tag == "R9") ? "R10 rt_data" : {tag, " rt_data"},
          longint'(rt_data), longint'(x_data));
      chk(rt_idx == 5'(rt), {tag, " rt_idx"}, longint'(rt_idx), longint'(rt));
    end
    chk(cr0_we == rc, "R6 cr0_we", longint'(cr0_we), longint'(rc));
    if (rc) begin
      chk(cr0[3:1] == {1'b0, !x_eq, x_eq}, (tag == "R9") ? "R9 cr0" : "R6 cr0",
          longint'(cr0[3:1]), longint'({1'b0, !x_eq, x_eq}));
      chk(cr0[0] == x_so, "R7 so", longint'(cr0[0]), longint'(x_so));
    end
    chk(mvl == VLW'(e_mvl), {tag, " mvl"}, longint'(mvl), longint'(e_mvl));
    chk(vl == VLW'(e_vl), {tag, " vl"}, longint'(vl), longint'(e_vl));
    chk(srcstep == VLW'(e_src) && dststep == VLW'(e_dst), {tag, " steps"},
        longint'({srcstep, dststep}), longint'({8'(e_src), 8'(e_dst)}));
    chk(vfirst == e_vf, "R11 vfirst", longint'(vfirst), longint'(e_vf));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(out_valid == 0 && in_ready == 1, "R12 reset handshake", longint'({out_valid, in_ready}), 1);
    chk(mvl == 1 && vl == 0, "R12 reset lengths", longint'({mvl, vl}), longint'({8'd1, 8'd0}));
    chk(srcstep == 0 && dststep == 0 && vfirst == 0, "R12 reset steps", longint'({srcstep, dststep}), 0);

    apply(mk(0, 0, 7, 1, 0, 0, 1), 0, 0, 0, 0);      // R2 max length 8
    apply(mk(0, 0, 4, 0, 1, 0, 1), 0, 0, 0, 0);      // R3 length 5
    apply(mk(0, 0, 99, 0, 1, 0, 1), 0, 0, 0, 0);     // R3/R7 clipped to 8
    apply(mk(0, 0, 127, 1, 1, 0, 1), 0, 0, 0, 0);    // R3 new max 128 used
    apply(mk(3, 0, 0, 0, 1, 0, 1), 0, 300, 0, 0);    // R4 CTR clipped, SO
    apply(mk(3, 0, 0, 0, 1, 0, 1), 0, 0, 0, 0);      // R4 zero -> EQ (R6)
    apply(mk(0, 4, 0, 0, 1, 0, 1), 1000, 0, 0, 0);   // R5 clipped, no SO
    apply(mk(7, 4, 0, 0, 1, 0, 1), 17, 0, 0, 0);     // R5 with RT
    apply(mk(5, 0, 0, 0, 0, 0, 1), 0, 0, 0, 0);      // R8 read length
    apply(mk(0, 0, 3, 1, 0, 0, 0), 0, 0, 0, 0);      // R2 shrink to 4
    apply(mk(0, 0, 3, 0, 1, 1, 0), 0, 0, 0, 0);      // R11 flag set, len 4
    for (int i = 0; i < 5; i++)                       // R9 walk to wrap, R10
      apply(mk(2, 0, (i % 2) ? 6 : 5, 0, 0, 1, 1), 0, 0, e_src + 1, e_dst + 1);
    apply(mk(2, 0, 1, 0, 0, 1, 1), 0, 0, 1, 3);      // R10 other SVi, no write
    apply(mk(2, 0, 5, 0, 0, 1, 1), 0, 0, 2, 4);      // R9 dst beyond -> wrap
    apply({6'd21, mk(3, 0, 9, 1, 1, 0, 1)} [31:0] & 32'h57FF_FFFF, 0, 9, 0, 0); // R1 bad opcode
    apply(mk(3, 0, 9, 1, 1, 0, 1) ^ 32'h2, 0, 9, 0, 0); // R1 bad sub-opcode

    // R12 back-pressure: result held, no new accept
    @(negedge clk);
    out_ready = 1'b0;
    apply(mk(0, 0, 20, 1, 1, 0, 0), 0, 0, 0, 0);
    @(negedge clk);
    insn = mk(0, 0, 2, 1, 1, 0, 0); in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 0 && out_valid == 1, "R12 stall", longint'({in_ready, out_valid}), 1);
      chk(vl == VLW'(e_vl), "R12 vl frozen", longint'(vl), longint'(e_vl));
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R12 drain", longint'(out_valid), 0);

    for (int n = 0; n < 400; n++) begin
      int rt, ra, svi;
      bit ms, vs, vf;
      logic [31:0] w;
      longint unsigned rv, cv;
      rt  = ($urandom % 3 == 0) ? 0 : int'($urandom % 32);
      ra  = ($urandom % 2 == 0) ? 0 : int'($urandom % 32);
      svi = ($urandom % 4 == 0) ? 5 + int'($urandom % 2) : int'($urandom % 128);
      ms = ($urandom % 4 == 0); vs = ($urandom % 2 == 0); vf = ($urandom % 2 == 0);
      w = mk(rt, ra, svi, ms, vs, vf, $urandom % 2);
      if ($urandom % 20 == 0) w[31:26] = 6'($urandom);
      rv = ($urandom % 3 == 0) ? {$urandom, $urandom} : longint'($urandom % 200);
      cv = ($urandom % 3 == 0) ? {$urandom, $urandom} : longint'($urandom % 200);
      apply(w, rv, cv, e_src + 1 + int'($urandom % 3), e_dst + 1 + int'($urandom % 3));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule